// File: doc/BRIEF.md
# Tuning Synthesiser Serial Control Slave

This block is the two-wire serial slave that programs a frequency synthesiser for a tuner. It watches the clock and data lines of an I2C bus through a short synchroniser clocked by the system clock. When it recognises its own address it acknowledges by pulling the data line low. In a write it sorts each following data byte into one of two fixed register pairs. One pair holds a 15-bit divide ratio. The other pair holds an 8-bit control byte and a 5-bit output-port byte.

In a read it sends back a status byte made of five fields:

- a power-on flag;
- the lock flag;
- three sampled port levels;
- a 3-bit converter code.

A read runs byte after byte for as long as the master acknowledges. The block stops sending when the master does not acknowledge.

The stored values are plain register outputs for the rest of the synthesiser. A reset or a power-on pulse clears all of them and raises the power-on flag. That flag stays up until a read transaction is closed by a real STOP.

Top module: `tuner_i2c_ctrl`

## Requirements
- R1: After `rst_n` low or a `por_i` pulse, the divide ratio, control byte and port byte are all zero, the data line is released, and the power-on flag (status bit 7) reads 1.
- R2: An address byte is accepted only when its upper five bits are 11000 and its bits 2:1 equal either 01 or `addr_sel_i`. Bit 0 selects read (1) or write (0). With any other address the block gives no acknowledge, and the data bytes that follow leave every register unchanged.
- R3: After an accepted address, and after every data byte received in a write, the block pulls the data line low during the ninth clock.
- R4: A write data byte that starts a pair and has bit 7 equal to 0 loads ratio bits 14:8 from its bits 6:0. The next byte always loads ratio bits 7:0.
- R5: A write data byte that starts a pair and has bit 7 equal to 1 is stored whole as the control byte. The next byte always loads the port byte from its bits 7:3.
- R6: Pairs of either kind may follow one another in the same transaction until STOP. Every START makes the next data byte the first of a pair.
- R7: A byte cut off by a START or a STOP before its eighth bit changes no register. Registers change only when a byte completes.
- R8: The status byte is sent MSB first as {power-on flag, `lock_i`, `port_in_i[2]`, `port_in_i[1]`, `port_in_i[0]`, `adc_i[2:0]`}. A 0 is sent by pulling the line low.
- R9: If the master leaves the line high in a status acknowledge slot, the block releases the line and sends nothing more until the next START. Clocked bits then read as all ones.
- R10: The power-on flag is cleared only by a STOP that closes a transaction with an accepted read address. A STOP after a write leaves it set. A `por_i` pulse in the same cycle as such a STOP leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_i | input | 1 | Power-on / undervoltage pulse, synchronous |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| addr_sel_i | input | 2 | Selectable address code (00, 10 or 11) |
| lock_i | input | 1 | Phase lock flag for the status byte |
| port_in_i | input | 3 | Port levels {P7, P5, P4} |
| adc_i | input | 3 | Converter code for the status byte |
| div_ratio_o | output | 15 | Programmed divide ratio |
| ctrl_o | output | 8 | Programmed control byte |
| port_o | output | 5 | Programmed port byte, P7 in bit 4 |

## Verification
The power-on flag has two sources that can act in the same system-clock cycle. A `por_i` pulse sets it, and a STOP that ends a read clears it. The bench provokes this by raising `por_i` at the moment it lifts the data line to form that STOP, and holding it across the synchroniser delay. It then reads status: the flag must still be 1 and all registers must be zero, because the set has priority over the clear.

// File: rtl/tic_pkg.sv
package tic_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CNT_W = $clog2(BYTE_W);
  localparam logic [4:0] ADDR_PREFIX = 5'b11000;
  localparam logic [1:0] ADDR_ALWAYS = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_HOLD,
    ST_ACK,
    ST_TX,
    ST_MACK
  } link_st_e;

  typedef enum logic [1:0] {
    SL_FIRST,
    SL_RATIO_LO,
    SL_PORT
  } slot_e;
endpackage

// File: rtl/tic_line_sync.sv
module tic_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic scl_prev;
  logic sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe[0] <= scl_i;
      sda_pipe[0] <= sda_i;
      for (int k = 1; k < STAGES; k++) begin
        scl_pipe[k] <= scl_pipe[k-1];
        sda_pipe[k] <= sda_pipe[k-1];
      end
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_prev;
  assign scl_fall_o = ~scl_o & scl_prev;
  assign start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
  assign stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;
endmodule

// File: rtl/tic_link_fsm.sv
module tic_link_fsm
  import tic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [1:0]        addr_sel_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              sda_pull_o,
  output logic              wr_stb_o,
  output logic [BYTE_W-1:0] wr_byte_o,
  output logic              txn_start_o,
  output logic              rd_end_o,
  output logic              idle_o
);
  link_st_e             st;
  logic [BIT_CNT_W-1:0] cnt;
  logic [BYTE_W-1:0]    shreg;
  logic                 addr_phase;
  logic                 rd;
  logic                 rd_seen;
  logic [BYTE_W-1:0]    full;
  logic                 addr_hit;

  assign full     = {shreg[BYTE_W-2:0], sda_s_i};
  assign addr_hit = (full[7:3] == ADDR_PREFIX) &&
                    ((full[2:1] == ADDR_ALWAYS) || (full[2:1] == addr_sel_i));
  assign idle_o   = (st == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      cnt         <= '0;
      shreg       <= '0;
      addr_phase  <= 1'b0;
      rd          <= 1'b0;
      rd_seen     <= 1'b0;
      sda_pull_o  <= 1'b0;
      wr_stb_o    <= 1'b0;
      wr_byte_o   <= '0;
      txn_start_o <= 1'b0;
      rd_end_o    <= 1'b0;
    end else if (clr_i) begin
      st          <= ST_IDLE;
      cnt         <= '0;
      addr_phase  <= 1'b0;
      rd          <= 1'b0;
      rd_seen     <= 1'b0;
      sda_pull_o  <= 1'b0;
      wr_stb_o    <= 1'b0;
      txn_start_o <= 1'b0;
      rd_end_o    <= 1'b0;
    end else begin
      wr_stb_o    <= 1'b0;
      txn_start_o <= 1'b0;
      rd_end_o    <= 1'b0;
      if (start_i) begin
        st          <= ST_RX;
        cnt         <= '0;
        addr_phase  <= 1'b1;
        rd          <= 1'b0;
        rd_seen     <= 1'b0;
        sda_pull_o  <= 1'b0;
        txn_start_o <= 1'b1;
      end else if (stop_i) begin
        st         <= ST_IDLE;
        sda_pull_o <= 1'b0;
        rd_end_o   <= rd_seen;
        rd_seen    <= 1'b0;
      end else begin
        case (st)
          ST_RX: if (scl_rise_i) begin
            shreg <= full;
            cnt   <= cnt + 1'b1;
            if (cnt == BIT_CNT_W'(BYTE_W - 1)) begin
              if (addr_phase) begin
                if (addr_hit) begin
                  rd         <= full[0];
                  rd_seen    <= full[0];
                  addr_phase <= 1'b0;
                  st         <= ST_HOLD;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                wr_stb_o  <= 1'b1;
                wr_byte_o <= full;
                st        <= ST_HOLD;
              end
            end
          end
          ST_HOLD: if (scl_fall_i) begin
            sda_pull_o <= 1'b1;
            st         <= ST_ACK;
          end
          ST_ACK: if (scl_fall_i) begin
            cnt <= '0;
            if (rd) begin
              shreg      <= status_i;
              sda_pull_o <= ~status_i[BYTE_W-1];
              st         <= ST_TX;
            end else begin
              sda_pull_o <= 1'b0;
              st         <= ST_RX;
            end
          end
          ST_TX: if (scl_fall_i) begin
            if (cnt == BIT_CNT_W'(BYTE_W - 1)) begin
              sda_pull_o <= 1'b0;
              st         <= ST_MACK;
            end else begin
              sda_pull_o <= ~shreg[BYTE_W-2];
              shreg      <= {shreg[BYTE_W-2:0], 1'b0};
              cnt        <= cnt + 1'b1;
            end
          end
          ST_MACK: if (scl_rise_i) begin
            st <= sda_s_i ? ST_IDLE : ST_ACK;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/tic_write_steer.sv
module tic_write_steer
  import tic_pkg::*;
#(
  parameter int DIV_W  = 15,
  parameter int PORT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              txn_start_i,
  input  logic              wr_stb_i,
  input  logic [BYTE_W-1:0] wr_byte_i,
  output logic [DIV_W-1:0]  div_o,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic [PORT_W-1:0] port_o
);
  localparam int HI_W = DIV_W - BYTE_W;

  slot_e slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot   <= SL_FIRST;
      div_o  <= '0;
      ctrl_o <= '0;
      port_o <= '0;
    end else if (clr_i) begin
      slot   <= SL_FIRST;
      div_o  <= '0;
      ctrl_o <= '0;
      port_o <= '0;
    end else if (txn_start_i) begin
      slot <= SL_FIRST;
    end else if (wr_stb_i) begin
      case (slot)
        SL_FIRST: begin
          if (wr_byte_i[BYTE_W-1]) begin
            ctrl_o <= wr_byte_i;
            slot   <= SL_PORT;
          end else begin
            div_o[DIV_W-1:BYTE_W] <= wr_byte_i[HI_W-1:0];
            slot                  <= SL_RATIO_LO;
          end
        end
        SL_RATIO_LO: begin
          div_o[BYTE_W-1:0] <= wr_byte_i;
          slot              <= SL_FIRST;
        end
        SL_PORT: begin
          port_o <= wr_byte_i[BYTE_W-1 -: PORT_W];
          slot   <= SL_FIRST;
        end
        default: slot <= SL_FIRST;
      endcase
    end
  end
endmodule

// File: rtl/tuner_i2c_ctrl.sv
module tuner_i2c_ctrl
  import tic_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 15,
  parameter int PORT_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [1:0]        addr_sel_i,
  input  logic              lock_i,
  input  logic [2:0]        port_in_i,
  input  logic [2:0]        adc_i,
  output logic [DIV_W-1:0]  div_ratio_o,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic [PORT_W-1:0] port_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_w, stop_w;
  logic wr_stb_w, txn_start_w, rd_end_w, link_idle_w;
  logic [BYTE_W-1:0] wr_byte_w;
  logic [BYTE_W-1:0] status_w;
  logic por_flag_q;

  tic_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_w),
    .stop_o     (stop_w)
  );

  // Set by reset or power-on pulse; cleared by a STOP that closes a read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        por_flag_q <= 1'b1;
    else if (por_i)    por_flag_q <= 1'b1;
    else if (rd_end_w) por_flag_q <= 1'b0;
  end

  assign status_w = {por_flag_q, lock_i, port_in_i, adc_i};

  tic_link_fsm u_link (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (por_i),
    .sda_s_i     (sda_s),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_w),
    .stop_i      (stop_w),
    .addr_sel_i  (addr_sel_i),
    .status_i    (status_w),
    .sda_pull_o  (sda_pull_o),
    .wr_stb_o    (wr_stb_w),
    .wr_byte_o   (wr_byte_w),
    .txn_start_o (txn_start_w),
    .rd_end_o    (rd_end_w),
    .idle_o      (link_idle_w)
  );

  tic_write_steer #(.DIV_W(DIV_W), .PORT_W(PORT_W)) u_steer (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (por_i),
    .txn_start_i (txn_start_w),
    .wr_stb_i    (wr_stb_w),
    .wr_byte_i   (wr_byte_w),
    .div_o       (div_ratio_o),
    .ctrl_o      (ctrl_o),
    .port_o      (port_o)
  );
endmodule

// File: rtl/tic_chk.sv
module tic_chk #(
  parameter int DIV_W  = 15,
  parameter int PORT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              por_i,
  input logic              stop_evt,
  input logic              wr_stb,
  input logic              link_idle,
  input logic              por_flag,
  input logic              sda_pull_o,
  input logic [DIV_W-1:0]  div_ratio_o,
  input logic [7:0]        ctrl_o,
  input logic [PORT_W-1:0] port_o
);
  AST_REGS_HOLD_MIDBYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && !por_i) |=> ($stable(div_ratio_o) && $stable(ctrl_o) && $stable(port_o))); // R7

  AST_POR_CLEARS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    por_i |=> (por_flag && div_ratio_o == '0 && ctrl_o == '0 && port_o == '0 && !sda_pull_o)); // R1

  AST_STOP_RELEASES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pull_o); // R9

  AST_IDLE_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    link_idle |-> !sda_pull_o); // R9

  AST_FLAG_FALLS_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por_flag) |-> $past(stop_evt, 2)); // R10

  AST_COMMIT_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !link_idle); // R2
endmodule

bind tuner_i2c_ctrl tic_chk #(.DIV_W(DIV_W), .PORT_W(PORT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .por_i       (por_i),
  .stop_evt    (stop_w),
  .wr_stb      (wr_stb_w),
  .link_idle   (link_idle_w),
  .por_flag    (por_flag_q),
  .sda_pull_o  (sda_pull_o),
  .div_ratio_o (div_ratio_o),
  .ctrl_o      (ctrl_o),
  .port_o      (port_o)
);

// File: tb/sim_tuner_i2c_ctrl.sv
module sim_tuner_i2c_ctrl;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_i = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] addr_sel = 2'b00;
  logic lock = 1'b0;
  logic [2:0] pin = 3'b000;
  logic [2:0] adc = 3'b000;
  logic sda_pull;
  logic sda_line;
  logic [14:0] div;
  logic [7:0] ctrl;
  logic [4:0] port;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [14:0] e_div = '0;
  logic [7:0] e_ctrl = '0;
  logic [4:0] e_port = '0;

  assign sda_line = sda_m & ~sda_pull;

  always #10 clk = ~clk;

  tuner_i2c_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .por_i(por_i), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .addr_sel_i(addr_sel), .lock_i(lock),
    .port_in_i(pin), .adc_i(adc), .div_ratio_o(div), .ctrl_o(ctrl), .port_o(port)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog R1..: act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  function automatic logic [7:0] status_exp(logic p, logic l, logic [2:0] pi, logic [2:0] a);
    return {p, l, pi, a};
  endfunction

  function automatic logic [7:0] addr_byte(logic [1:0] ma, logic rw);
    return {5'b11000, ma, rw};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wq(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(Q);
    scl = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(Q);
    scl = 1'b1; wq(Q);
    sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic sbit(logic v);
    sda_m = v; wq(Q);
    scl = 1'b1; wq(2*Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic rbit(output logic v);
    sda_m = 1'b1; wq(Q);
    scl = 1'b1; wq(Q);
    v = sda_line; wq(Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic wbyte(logic [7:0] b, output logic ack);
    logic v;
    for (int i = 7; i >= 0; i--) sbit(b[i]);
    rbit(v);
    ack = ~v;
  endtask

  task automatic rbyte(output logic [7:0] b, input logic mack);
    logic v;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      rbit(v);
      b = {b[6:0], v};
    end
    sbit(~mack);
  endtask

  task automatic chk_regs(string req);
    chk({req, " div"}, 32'(div), 32'(e_div));
    chk({req, " ctrl"}, 32'(ctrl), 32'(e_ctrl));
    chk({req, " port"}, 32'(port), 32'(e_port));
  endtask

  initial begin
    logic ack;
    logic [7:0] rb;
    void'($urandom(32'd4813));
    wq(5);
    rst_n = 1'b1;
    wq(4);
    chk_regs("R1 reset");
    chk("R1 line released", 32'(sda_pull), 0);

    // Status read with power-on flag set, then NACK ends the read.
    lock = 1'b1; pin = 3'b101; adc = 3'b010;
    i2c_start();
    wbyte(addr_byte(2'b01, 1'b1), ack);
    chk("R3 read address ack", 32'(ack), 1);
    rbyte(rb, 1'b1);
    chk("R8 status byte 1", 32'(rb), 32'(status_exp(1'b1, 1'b1, 3'b101, 3'b010)));
    rbyte(rb, 1'b0);
    chk("R8 status byte 2", 32'(rb), 32'(status_exp(1'b1, 1'b1, 3'b101, 3'b010)));
    rbyte(rb, 1'b0);
    chk("R9 silent after nack", 32'(rb), 32'hFF);
    i2c_stop();
    i2c_start();
    wbyte(addr_byte(2'b01, 1'b1), ack);
    rbyte(rb, 1'b0);
    i2c_stop();
    chk("R10 flag cleared after read stop", 32'(rb[7]), 0);

    // Address matching.
    addr_sel = 2'b00;
    i2c_start(); wbyte(addr_byte(2'b10, 1'b0), ack);
    chk("R2 ma=10 sel=00 nack", 32'(ack), 0);
    wbyte(8'h12, ack); wbyte(8'h34, ack);
    i2c_stop();
    chk_regs("R2 ignored data");
    i2c_start(); wbyte(addr_byte(2'b00, 1'b0), ack); i2c_stop();
    chk("R2 ma=00 sel=00 ack", 32'(ack), 1);
    addr_sel = 2'b11;
    i2c_start(); wbyte(addr_byte(2'b11, 1'b0), ack); i2c_stop();
    chk("R2 ma=11 sel=11 ack", 32'(ack), 1);
    i2c_start(); wbyte(addr_byte(2'b00, 1'b0), ack); i2c_stop();
    chk("R2 ma=00 sel=11 nack", 32'(ack), 0);
    i2c_start(); wbyte(8'hA2, ack); i2c_stop();
    chk("R2 wrong prefix nack", 32'(ack), 0);

    // Control pair then frequency pair in one transaction.
    i2c_start(); wbyte(addr_byte(2'b01, 1'b0), ack);
    wbyte(8'h8E, ack);
    chk("R3 data byte ack", 32'(ack), 1);
    wbyte(8'h50, ack); wbyte(8'h12, ack); wbyte(8'h34, ack);
    i2c_stop();
    e_ctrl = 8'h8E; e_port = 5'b01010; e_div = {7'h12, 8'h34};
    chk_regs("R6 ctrl then freq");
    // Frequency pair then control pair.
    i2c_start(); wbyte(addr_byte(2'b01, 1'b0), ack);
    wbyte(8'h2A, ack); wbyte(8'h0F, ack); wbyte(8'hA2, ack); wbyte(8'hFF, ack);
    i2c_stop();
    e_div = {7'h2A, 8'h0F}; e_ctrl = 8'hA2; e_port = 5'h1F;
    chk_regs("R4 R5 freq then ctrl");

    // Mid-byte aborts.
    i2c_start(); wbyte(addr_byte(2'b01, 1'b0), ack);
    wbyte(8'h55, ack);
    for (int i = 0; i < 4; i++) sbit(1'b1);
    i2c_stop();
    e_div[14:8] = 7'h55;
    chk_regs("R7 abort in ratio low byte");
    i2c_start(); wbyte(addr_byte(2'b01, 1'b0), ack);
    for (int i = 0; i < 3; i++) sbit(1'b0);
    i2c_stop();
    chk_regs("R7 abort in first byte");
    i2c_start(); wbyte(addr_byte(2'b01, 1'b0), ack);
    wbyte(8'hC6, ack); wbyte(8'hF8, ack);
    i2c_stop();
    e_ctrl = 8'hC6; e_port = 5'h1F;
    chk_regs("R6 start restarts pair");

    // Write then stop must not clear a freshly set flag; por pulse clears registers.
    por_i = 1'b1; wq(2); por_i = 1'b0; wq(2);
    e_div = '0; e_ctrl = '0; e_port = '0;
    chk_regs("R1 por pulse");
    i2c_start(); wbyte(addr_byte(2'b01, 1'b0), ack); wbyte(8'h01, ack); wbyte(8'h02, ack); i2c_stop();
    e_div = {7'h01, 8'h02};
    i2c_start(); wbyte(addr_byte(2'b01, 1'b1), ack); rbyte(rb, 1'b0);
    chk("R10 flag kept after write stop", 32'(rb[7]), 1);
    // STOP closing this read collides with a power-on pulse.
    sda_m = 1'b0; wq(Q);
    scl = 1'b1; wq(Q);
    sda_m = 1'b1; por_i = 1'b1; wq(6); por_i = 1'b0; wq(Q);
    e_div = '0;
    chk_regs("R1 por during stop");
    i2c_start(); wbyte(addr_byte(2'b01, 1'b1), ack); rbyte(rb, 1'b0); i2c_stop();
    chk("R10 set wins over clear", 32'(rb[7]), 1);

    // Random writes and status reads.
    for (int it = 0; it < 24; it++) begin
      logic [1:0] ma;
      int npairs;
      case ($urandom % 3)
        0: addr_sel = 2'b00;
        1: addr_sel = 2'b10;
        default: addr_sel = 2'b11;
      endcase
      ma = (($urandom % 2) == 0) ? 2'b01 : addr_sel;
      i2c_start();
      wbyte(addr_byte(ma, 1'b0), ack);
      chk("R2 random address ack", 32'(ack), 1);
      npairs = 1 + int'($urandom % 3);
      for (int p = 0; p < npairs; p++) begin
        logic [7:0] b1;
        logic [7:0] b2;
        b1 = 8'($urandom);
        b2 = 8'($urandom);
        wbyte(b1, ack);
        wbyte(b2, ack);
        if (b1[7]) begin
          e_ctrl = b1;
          e_port = b2[7:3];
        end else begin
          e_div = {b1[6:0], b2};
        end
      end
      i2c_stop();
      chk_regs("R4 R5 R6 random pairs");
      lock = 1'($urandom); pin = 3'($urandom); adc = 3'($urandom);
      i2c_start();
      wbyte(addr_byte(ma, 1'b1), ack);
      rbyte(rb, 1'b0);
      i2c_stop();
      chk("R8 random status", 32'(rb), 32'(status_exp(1'b0, lock, pin, adc)));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule